// File: doc/BRIEF.md
# Filtered Hysteresis Threshold Comparator

The block watches a stream of 10-bit unsigned converter samples, each qualified by a valid strobe, and drives one binary decision from a pair of programmable limits. The decision rises when the compared value exceeds the upper limit, falls when it drops under the lower limit, and otherwise keeps its last state. This gives a noise-tolerant switching band.

The compared value is either the raw sample or a running average over the most recent 2, 4 or 8 samples, chosen by a configuration field. Every write to that field empties the sample history. Until the window has filled again, empty slots count as zero. The latest raw sample and the latest compared (filtered) value are both held and can be read back through a small register port. That port also sets the two limits and the window selection.

Top module: `hyst_cmp_top`

## Requirements
- R1: After reset `cmp_o` is low, and reads of the upper limit (address 0), the lower limit (address 1), the window field (address 2), the raw sample (address 3) and the filtered value (address 4) all return zero.
- R2: When a valid sample yields a compared value strictly greater than the upper limit, `cmp_o` is high after the clock edge that accepts that sample.
- R3: When a valid sample yields a compared value strictly less than the lower limit, `cmp_o` is low after the clock edge that accepts that sample.
- R4: When the compared value lies between the limits, or equals either of them, `cmp_o` keeps its previous value.
- R5: With window field 0 (bypass), each raw sample is compared directly, and the filtered readback equals that sample.
- R6: With window field k = 1, 2 or 3, the compared value is the sum of the last 2^k samples shifted right by k and truncated to 10 bits.
- R7: Any write to address 2 clears the sample history. Later averages treat not-yet-refilled slots as zero.
- R8: Address 3 reads the most recently accepted raw sample, and address 4 reads the most recently computed compared value.
- R9: When a write to address 2 and a valid sample fall in the same cycle, the history is cleared first. The sample then becomes the only entry of the new window and is averaged under the newly written field.
- R10: Cycles with the valid strobe low change neither `cmp_o` nor the raw readback. Writes to addresses 3 and 4 change nothing.
- R11: The running sum never overflows: eight samples of 1023 in the 8-sample window average to exactly 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 10 | Unsigned sample |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register address, used for both read and write |
| reg_wdata_i | input | 10 | Write data; bits [1:0] carry the window field at address 2 |
| reg_rdata_o | output | 10 | Combinational read data for `reg_addr_i` |
| cmp_o | output | 1 | Hysteresis decision |

## Verification
The critical collision is a window-field write landing in the same cycle as an accepted sample. In that cycle the history clear, the new averaging shift and the new sample all meet in one sum. The bench provokes it by asserting the write and the strobe together after the history has been loaded with large values. It then judges the result twice: through the decision, which must reflect only the lone new sample shifted by the new field, and through the filtered readback, which must show that same value.

// File: rtl/hyst_cmp_pkg.sv
package hyst_cmp_pkg;
  parameter int unsigned DW        = 10;
  parameter int unsigned LOG2_MAX  = 3;
  parameter int unsigned AW        = 3;
  localparam int unsigned MW       = $clog2(LOG2_MAX + 1);
  localparam int unsigned DEPTH    = 1 << LOG2_MAX;
  localparam int unsigned SW       = DW + LOG2_MAX;

  localparam logic [AW-1:0] A_UPPER = AW'(0);
  localparam logic [AW-1:0] A_LOWER = AW'(1);
  localparam logic [AW-1:0] A_CFG   = AW'(2);
  localparam logic [AW-1:0] A_RAW   = AW'(3);
  localparam logic [AW-1:0] A_FILT  = AW'(4);
endpackage

// File: rtl/hc_regs.sv
module hc_regs
  import hyst_cmp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] raw_i,
  input  logic [DW-1:0] filt_i,
  output logic [DW-1:0] upper_o,
  output logic [DW-1:0] lower_o,
  output logic          cfg_wr_o,
  output logic [MW-1:0] mode_eff_o,
  output logic [DW-1:0] rdata_o
);
  logic [MW-1:0] mode_q;

  assign cfg_wr_o   = we_i && (addr_i == A_CFG);
  // a same-cycle write applies to the sample accepted in that cycle
  assign mode_eff_o = cfg_wr_o ? wdata_i[MW-1:0] : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_o <= '0;
      lower_o <= '0;
      mode_q  <= '0;
    end else if (we_i) begin
      if (addr_i == A_UPPER) upper_o <= wdata_i;
      if (addr_i == A_LOWER) lower_o <= wdata_i;
      if (addr_i == A_CFG)   mode_q  <= wdata_i[MW-1:0];
    end
  end

  always_comb begin
    unique case (addr_i)
      A_UPPER: rdata_o = upper_o;
      A_LOWER: rdata_o = lower_o;
      A_CFG:   rdata_o = DW'(mode_q);
      A_RAW:   rdata_o = raw_i;
      A_FILT:  rdata_o = filt_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/hc_avg.sv
module hc_avg
  import hyst_cmp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          clr_i,
  input  logic [MW-1:0] mode_i,
  output logic [DW-1:0] raw_o,
  output logic [DW-1:0] filt_o,
  output logic [DW-1:0] cmp_val_o
);
  logic [DW-1:0]           hist_q [DEPTH];
  logic [SW-1:0]           sum_q, sum_base, sum_next;
  logic [DW-1:0]           oldest;
  logic [LOG2_MAX-1:0]     tail_idx;

  assign tail_idx = LOG2_MAX'((1 << mode_i) - 1);

  always_comb begin
    sum_base  = clr_i ? '0 : sum_q;
    oldest    = clr_i ? '0 : hist_q[tail_idx];
    sum_next  = sum_base + SW'(data_i) - SW'(oldest);
    cmp_val_o = DW'(sum_next >> mode_i);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hist_q[i] <= '0;
      else if (valid_i) begin
        if (i == 0)     hist_q[i] <= data_i;
        else if (clr_i) hist_q[i] <= '0;
        else            hist_q[i] <= hist_q[(i > 0) ? i-1 : 0];
      end else if (clr_i) hist_q[i] <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      raw_o  <= '0;
      filt_o <= '0;
    end else if (valid_i) begin
      sum_q  <= sum_next;
      raw_o  <= data_i;
      filt_o <= cmp_val_o;
    end else if (clr_i) begin
      sum_q  <= '0;
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> sum_q <= ((SW'(1) << mode_i) * SW'((1 << DW) - 1)));
endmodule

// File: rtl/hc_hyst.sv
module hc_hyst
  import hyst_cmp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] upper_i,
  input  logic [DW-1:0] lower_i,
  output logic          cmp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmp_o <= 1'b0;
    else if (valid_i) begin
      if (val_i > upper_i)      cmp_o <= 1'b1;
      else if (val_i < lower_i) cmp_o <= 1'b0;
    end
  end

  // R2
  rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (val_i > upper_i) |=> cmp_o);
  // R3
  fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (val_i < lower_i) && !(val_i > upper_i) |=> !cmp_o);
  // R4
  band_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !(val_i > upper_i) && !(val_i < lower_i) |=> $stable(cmp_o));
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cmp_o));
endmodule

// File: rtl/hyst_cmp_top.sv
module hyst_cmp_top
  import hyst_cmp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_data_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          cmp_o
);
  logic [DW-1:0] upper, lower, raw, filt, cmp_val;
  logic          cfg_wr;
  logic [MW-1:0] mode_eff;

  hc_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .raw_i(raw), .filt_i(filt),
    .upper_o(upper), .lower_o(lower),
    .cfg_wr_o(cfg_wr), .mode_eff_o(mode_eff), .rdata_o(reg_rdata_o)
  );

  hc_avg u_avg (
    .clk_i, .rst_ni,
    .valid_i(smp_valid_i), .data_i(smp_data_i),
    .clr_i(cfg_wr), .mode_i(mode_eff),
    .raw_o(raw), .filt_o(filt), .cmp_val_o(cmp_val)
  );

  hc_hyst u_hyst (
    .clk_i, .rst_ni,
    .valid_i(smp_valid_i), .val_i(cmp_val),
    .upper_i(upper), .lower_i(lower), .cmp_o
  );

  // R8
  raw_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> raw == $past(smp_data_i));
  // R10
  raw_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(raw));
endmodule

// File: tb/tb_hyst_cmp_top.sv
`timescale 1ns/1ps
module tb_hyst_cmp_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [9:0] data = '0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [9:0] wdata = '0;
  logic [9:0] rdata;
  logic       cmp;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { bit cmp; string tag; } exp_t;
  exp_t sb[$];

  // reference model state
  int  m_hist[8];
  int  m_mode = 0, m_up = 0, m_lo = 0, m_raw = 0, m_filt = 0;
  bit  m_cmp = 0;

  always #2.5 clk = ~clk;

  hyst_cmp_top dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid), .smp_data_i(data),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cmp_o(cmp)
  );

  task automatic model_clear(int mode);
    for (int i = 0; i < 8; i++) m_hist[i] = 0;
    m_mode = mode;
  endtask

  task automatic model_push(int s, string tag);
    int sum;
    exp_t e;
    for (int i = 7; i > 0; i--) m_hist[i] = m_hist[i-1];
    m_hist[0] = s;
    sum = 0;
    for (int i = 0; i < (1 << m_mode); i++) sum += m_hist[i];
    m_filt = (sum >> m_mode) & 1023;
    m_raw  = s;
    if (m_filt > m_up) m_cmp = 1;
    else if (m_filt < m_lo) m_cmp = 0;
    e.cmp = m_cmp; e.tag = tag;
    sb.push_back(e);
  endtask

  // all tasks start and end at a falling edge
  task automatic smp(int s, string tag);
    valid = 1; data = 10'(s);
    model_push(s, tag);
    @(posedge clk); @(negedge clk);
    valid = 0;
  endtask

  task automatic wr(int a, int d);
    we = 1; addr = 3'(a); wdata = 10'(d);
    if (a == 0) m_up = d;
    if (a == 1) m_lo = d;
    if (a == 2) model_clear(d & 3);
    @(posedge clk); @(negedge clk);
    we = 0;
  endtask

  task automatic wr_cfg_and_smp(int mode, int s, string tag);
    we = 1; addr = 3'd2; wdata = 10'(mode);
    valid = 1; data = 10'(s);
    model_clear(mode);
    model_push(s, tag);
    @(posedge clk); @(negedge clk);
    we = 0; valid = 0;
  endtask

  task automatic rd(int a, int exp, string tag);
    addr = 3'(a);
    #0.5;
    checks++;
    if (rdata !== 10'(exp)) begin
      failures++;
      $display("FAIL %s: addr %0d read %0d expected %0d", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_cmp(bit exp, string tag);
    checks++;
    if (cmp !== exp) begin
      failures++;
      $display("FAIL %s: cmp_o %0b expected %0b", tag, cmp, exp);
    end
  endtask

  // monitor: compare output after each accepted sample
  logic took = 0;
  always @(posedge clk) took <= valid;
  always @(negedge clk) begin
    if (took && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk_cmp(e.cmp, e.tag);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_clear(0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk_cmp(0, "R1");
    for (int a = 0; a < 5; a++) rd(a, 0, "R1");

    // bypass mode, hysteresis band 200..500
    wr(0, 500); wr(1, 200);
    smp(600, "R2 R5");
    rd(3, 600, "R8"); rd(4, 600, "R5");
    smp(500, "R4 equal upper");
    smp(200, "R4 equal lower");
    smp(199, "R3");
    smp(300, "R4 inside band");
    smp(500, "R4 equal upper low state");
    smp(501, "R2");

    // R10: idle cycles and read-only writes
    data = 10'd0;
    repeat (4) @(negedge clk);
    chk_cmp(1, "R10 idle");
    rd(3, 501, "R10 raw idle");
    wr(3, 5); wr(4, 7);
    rd(3, 501, "R10 ro write"); rd(4, 501, "R10 ro write");
    chk_cmp(1, "R10 ro write");

    // 4-sample window, starting from cleared history
    smp(100, "R3 setup");
    wr(2, 2);
    rd(2, 2, "R7 cfg readback");
    smp(1000, "R7 partial window");
    rd(4, 250, "R7");
    smp(1000, "R6"); smp(1000, "R6");
    rd(4, 750, "R6");
    smp(1000, "R6 full");
    smp(0, "R6 slide"); smp(0, "R6 slide"); smp(0, "R6 slide");
    rd(4, 250, "R6 4tap");
    smp(0, "R3 4tap");
    rd(4, 0, "R6 4tap drained");

    // 2-sample window with truncation
    wr(2, 1);
    smp(801, "R6 2tap"); smp(2, "R6 2tap");
    rd(4, 401, "R6 truncation");
    rd(3, 2, "R8");

    // 8-sample window at full scale
    wr(0, 1000); wr(1, 900);
    wr(2, 3);
    for (int i = 0; i < 8; i++) smp(1023, "R11");
    rd(4, 1023, "R11");
    smp(1023, "R11 steady");

    // R9: config write collides with a sample
    wr_cfg_and_smp(2, 800, "R9");
    rd(4, 200, "R9 filtered");
    rd(2, 2, "R9 cfg");
    wr_cfg_and_smp(0, 950, "R9 bypass");
    rd(4, 950, "R9 bypass filtered");

    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d left, expected 0", sb.size());
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule